// File: doc/BRIEF.md
# Video Gate-Array Control Decoder and Memory Bank Mapper

This block watches the processor's I/O cycles and decodes the writes meant for the video gate array. It turns them into pen and colour strobes, a pending video mode, a pulse that clears the raster interrupt counter, and the ROM/RAM layout of the four 16 KB processor windows. For each window it outputs the physical RAM bank that takes writes, and a flag that says whether reads come from ROM. The same address decode drives the chip selects of the display controller (CRTC) and the parallel I/O port (PIO). It also produces the processor wait line, which runs on a fixed four-cycle cadence.

The gate array does not look at the bus direction. It acts on any I/O cycle in its address range. During an I/O read it takes whatever byte is on the bus, and that byte is the bitwise AND of the read data from every device that is selected. Decoded settings and strobes appear on the outputs one clock after the I/O cycle. Chip selects, the read-data merge and the wait line are decoded combinationally.

Top module: `gabank_ctrl`

## Requirements
- R1: After reset the outputs are as follows. `next_mode` is 2 and both ROM flags are 1, so `rd_rom` = 4'b1001. `wr_bank` holds banks 0,1,2,3 for windows 0..3. `upper_disk` is 0 and no strobe is high.
- R2: The gate array acts only on an I/O cycle (`io_wr` or `io_rd`) with `io_addr[15:14]` = 2'b01. Any other cycle leaves all of its registered outputs unchanged and raises none of its strobes.
- R3: A gate-array byte with bits [7:6] = 00 pulses `pen_stb` for one cycle. A byte with bits [7:6] = 01 pulses `colour_stb` for one cycle. In both cases `ga_val` carries bits [4:0] of the byte.
- R4: A byte with bits [7:6] = 10 loads `next_mode` from bits [1:0]. Bit 2 = 1 clears `low_rom_en` (0 sets it). Bit 3 = 1 clears `high_rom_en` (0 sets it). Bit 4 = 1 pulses `irq_cnt_clr` for one cycle.
- R5: A byte with bits [7:6] = 11 loads the bank configuration from bits [2:0], but only while `exp128_en` is 1. When `exp128_en` is 0 the byte has no effect. The banks for windows 0..3 are set by the configuration as follows:
  - 0: 0,1,2,3
  - 1: 0,1,2,7
  - 2: 4,5,6,7
  - 3: 0,3,2,7
  - 4..7: 0,N,2,3, where N is the configuration number.

  Window w is `wr_bank[3w+2:3w]`.
- R6: `rd_rom[0]` equals `low_rom_en` and `rd_rom[3]` equals `high_rom_en`. `rd_rom[2:1]` is always 0, so reads in the two middle windows follow the write banks.
- R7: `crtc_cs` = I/O cycle and `io_addr[14]` = 0, with `crtc_fn` = `io_addr[9:8]`. `pio_cs` = I/O cycle and `io_addr[11]` = 0, with `pio_port` = `io_addr[9:8]`.
- R8: `io_rdata` starts at 8'hFF. It is ANDed with `pio_rdata` when `pio_cs` is set during `io_rd`. It is ANDed with `crtc_rdata` when `crtc_cs` is set during `io_rd` with `crtc_fn[1]` = 1.
- R9: During a gate-array `io_rd` cycle the byte decoded is `io_rdata`, not `io_wdata`.
- R10: An `io_wr` cycle with `io_addr[13]` = 0 sets `upper_disk` to 1 when the byte is 7, and clears it for any other byte.
- R11: `cpu_wait` is 0 in the first cycle after reset and then 1 for three cycles. This four-cycle pattern repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Data written by the processor |
| io_wr | input | 1 | I/O write cycle |
| io_rd | input | 1 | I/O read cycle |
| exp128_en | input | 1 | Allows RAM bank configuration |
| crtc_rdata | input | 8 | Read data from the CRTC |
| pio_rdata | input | 8 | Read data from the PIO |
| pen_stb | output | 1 | Pen-select strobe |
| colour_stb | output | 1 | Colour-write strobe |
| ga_val | output | 5 | Pen number or colour value |
| next_mode | output | 2 | Pending video mode |
| irq_cnt_clr | output | 1 | Interrupt-counter clear pulse |
| low_rom_en | output | 1 | Lowest window reads ROM |
| high_rom_en | output | 1 | Highest window reads ROM |
| upper_disk | output | 1 | Upper ROM is the disk ROM |
| wr_bank | output | 12 | Write bank per window, 3 bits each |
| rd_rom | output | 4 | Per-window read-from-ROM flag |
| crtc_cs | output | 1 | CRTC select |
| crtc_fn | output | 2 | CRTC access function |
| pio_cs | output | 1 | PIO select |
| pio_port | output | 2 | PIO port number |
| io_rdata | output | 8 | Merged I/O read data |
| cpu_wait | output | 1 | Processor wait line |

## Verification
The assertions assume a few things about the inputs. `io_wr` and `io_rd` are never high in the same cycle. Each input is stable for a whole clock cycle. `exp128_en` may change at any clock edge. The bench drives exactly one of no cycle, a write, or a read in each step. It changes inputs only one time unit after a rising edge. It biases random addresses toward the gate-array range, and toggles the 128K enable often enough to cover both sides of R5.

// File: rtl/gabank_pkg.sv
package gabank_pkg;
    parameter int unsigned WIN_N  = 4;
    parameter int unsigned BANK_W = 3;
    parameter int unsigned MODE_W = 2;
    parameter int unsigned VAL_W  = 5;
    parameter int unsigned DATA_W = 8;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              lo_rom;
        logic              hi_rom;
        logic [BANK_W-1:0] cfg;
        logic              upper_disk;
        logic              pen_stb;
        logic              col_stb;
        logic              irq_clr;
        logic [VAL_W-1:0]  val;
    } ctrl_t;

    // Physical bank used for writes in window win under configuration cfg.
    function automatic logic [BANK_W-1:0] bank_of(input logic [BANK_W-1:0] cfg, input int win);
        logic [BANK_W-1:0] b;
        case (win)
            0: b = (cfg == 3'd2) ? 3'd4 : 3'd0;
            1: begin
                case (cfg)
                    3'd0, 3'd1: b = 3'd1;
                    3'd2:       b = 3'd5;
                    3'd3:       b = 3'd3;
                    default:    b = cfg;
                endcase
            end
            2: b = (cfg == 3'd2) ? 3'd6 : 3'd2;
            default: b = (cfg == 3'd1 || cfg == 3'd2 || cfg == 3'd3) ? 3'd7 : 3'd3;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/gabank_io_decode.sv
module gabank_io_decode
    import gabank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] crtc_rdata,
    input  logic [DATA_W-1:0] pio_rdata,
    output logic              crtc_cs,
    output logic [1:0]        crtc_fn,
    output logic              pio_cs,
    output logic [1:0]        pio_port,
    output logic              ga_hit,
    output logic              rom_sel_wr,
    output logic [DATA_W-1:0] io_rdata
);
    logic io_cyc;
    logic crtc_rd;
    logic pio_rd;

    always_comb begin
        io_cyc     = io_wr | io_rd;
        crtc_cs    = io_cyc & ~io_addr[14];
        crtc_fn    = io_addr[9:8];
        pio_cs     = io_cyc & ~io_addr[11];
        pio_port   = io_addr[9:8];
        ga_hit     = io_cyc & (io_addr[15:14] == 2'b01);
        rom_sel_wr = io_wr & ~io_addr[13];
        crtc_rd    = io_rd & crtc_cs & crtc_fn[1];
        pio_rd     = io_rd & pio_cs;
        io_rdata   = {DATA_W{1'b1}};
        if (pio_rd)  io_rdata = io_rdata & pio_rdata;
        if (crtc_rd) io_rdata = io_rdata & crtc_rdata;
    end

    // R8: with no reading device selected the bus floats high
    assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(io_rd && !io_addr[11]) && !(io_rd && !io_addr[14] && io_addr[9])) |-> (io_rdata == 8'hFF));
    // R7: CRTC select only outside address bit 14
    assert_crtc_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        crtc_cs |-> (!io_addr[14] && (io_wr || io_rd)));
endmodule

// File: rtl/gabank_wait_gen.sv
module gabank_wait_gen #(
    parameter int unsigned PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic cpu_wait
);
    localparam int unsigned PH_W = $clog2(PHASES);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == PH_W'(PHASES - 1)) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign cpu_wait = (phase_q != '0);

    // R11: a released cycle is always followed by a waited one
    assert_wait_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wait |=> cpu_wait);
    // R11: each release closes a run of three waited cycles
    assert_wait_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_wait) |-> ($past(cpu_wait, 2) && $past(cpu_wait, 3)));
endmodule

// File: rtl/gabank_ctrl_regs.sv
module gabank_ctrl_regs
    import gabank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ga_hit,
    input  logic [DATA_W-1:0] ga_byte,
    input  logic              exp128_en,
    input  logic              rom_sel_wr,
    input  logic [DATA_W-1:0] rom_sel_val,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d         = ctrl_q;
        ctrl_d.pen_stb = 1'b0;
        ctrl_d.col_stb = 1'b0;
        ctrl_d.irq_clr = 1'b0;
        if (ga_hit) begin
            unique case (ga_byte[7:6])
                2'b00: begin
                    ctrl_d.pen_stb = 1'b1;
                    ctrl_d.val     = ga_byte[VAL_W-1:0];
                end
                2'b01: begin
                    ctrl_d.col_stb = 1'b1;
                    ctrl_d.val     = ga_byte[VAL_W-1:0];
                end
                2'b10: begin
                    ctrl_d.mode    = ga_byte[MODE_W-1:0];
                    ctrl_d.lo_rom  = ~ga_byte[2];
                    ctrl_d.hi_rom  = ~ga_byte[3];
                    ctrl_d.irq_clr = ga_byte[4];
                end
                default: begin
                    if (exp128_en) ctrl_d.cfg = ga_byte[BANK_W-1:0];
                end
            endcase
        end
        if (rom_sel_wr) ctrl_d.upper_disk = (rom_sel_val == 8'd7);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q            <= '0;
            ctrl_q.mode       <= 2'd2;
            ctrl_q.lo_rom     <= 1'b1;
            ctrl_q.hi_rom     <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R3: strobes never overlap
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_q.pen_stb, ctrl_q.col_stb, ctrl_q.irq_clr}));
    // R4: the clear pulse traces back to a control byte with bit 4 set
    assert_irq_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.irq_clr |-> $past(ga_hit && ga_byte[7:6] == 2'b10 && ga_byte[4]));
    // R5: configuration is frozen without the expansion enable
    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !exp128_en |=> $stable(ctrl_q.cfg));
endmodule

// File: rtl/gabank_ctrl.sv
module gabank_ctrl
    import gabank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             io_addr,
    input  logic [DATA_W-1:0]       io_wdata,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic                    exp128_en,
    input  logic [DATA_W-1:0]       crtc_rdata,
    input  logic [DATA_W-1:0]       pio_rdata,
    output logic                    pen_stb,
    output logic                    colour_stb,
    output logic [VAL_W-1:0]        ga_val,
    output logic [MODE_W-1:0]       next_mode,
    output logic                    irq_cnt_clr,
    output logic                    low_rom_en,
    output logic                    high_rom_en,
    output logic                    upper_disk,
    output logic [WIN_N*BANK_W-1:0] wr_bank,
    output logic [WIN_N-1:0]        rd_rom,
    output logic                    crtc_cs,
    output logic [1:0]              crtc_fn,
    output logic                    pio_cs,
    output logic [1:0]              pio_port,
    output logic [DATA_W-1:0]       io_rdata,
    output logic                    cpu_wait
);
    logic              ga_hit;
    logic              rom_sel_wr;
    logic [DATA_W-1:0] ga_byte;
    ctrl_t             ctrl_q;

    gabank_io_decode u_dec (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .crtc_rdata(crtc_rdata), .pio_rdata(pio_rdata),
        .crtc_cs(crtc_cs), .crtc_fn(crtc_fn), .pio_cs(pio_cs), .pio_port(pio_port),
        .ga_hit(ga_hit), .rom_sel_wr(rom_sel_wr), .io_rdata(io_rdata)
    );

    // The gate array ignores direction: on a read it sees the merged bus.
    assign ga_byte = io_rd ? io_rdata : io_wdata;

    gabank_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ga_hit(ga_hit), .ga_byte(ga_byte),
        .exp128_en(exp128_en), .rom_sel_wr(rom_sel_wr), .rom_sel_val(io_wdata),
        .ctrl_q(ctrl_q)
    );

    gabank_wait_gen #(.PHASES(4)) u_wait (
        .clk(clk), .rst_n(rst_n), .cpu_wait(cpu_wait)
    );

    assign pen_stb     = ctrl_q.pen_stb;
    assign colour_stb  = ctrl_q.col_stb;
    assign ga_val      = ctrl_q.val;
    assign next_mode   = ctrl_q.mode;
    assign irq_cnt_clr = ctrl_q.irq_clr;
    assign low_rom_en  = ctrl_q.lo_rom;
    assign high_rom_en = ctrl_q.hi_rom;
    assign upper_disk  = ctrl_q.upper_disk;

    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        assign wr_bank[w*BANK_W +: BANK_W] = bank_of(ctrl_q.cfg, w);
        if (w == 0) begin : g_lo
            assign rd_rom[w] = ctrl_q.lo_rom;
        end else if (w == WIN_N - 1) begin : g_hi
            assign rd_rom[w] = ctrl_q.hi_rom;
        end else begin : g_mid
            assign rd_rom[w] = 1'b0;
        end
    end

    // R2: traffic outside the gate-array range leaves its strobes low
    assert_ga_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !((io_wr || io_rd) && io_addr[15:14] == 2'b01) |=> !(pen_stb || colour_stb || irq_cnt_clr));
    // R6: middle windows always read RAM
    assert_mid_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rom[2:1] == 2'b00);
    // R5: banks move only after an enabled configuration byte
    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ga_hit && ga_byte[7:6] == 2'b11 && exp128_en) |=> $stable(wr_bank));
endmodule

// File: tb/tb_gabank_ctrl.sv
`timescale 1ns/1ps
module tb_gabank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0, exp128_en = 1'b0;
    logic [7:0]  crtc_rdata = 8'hFF, pio_rdata = 8'hFF;
    logic        pen_stb, colour_stb, irq_cnt_clr, low_rom_en, high_rom_en, upper_disk;
    logic [4:0]  ga_val;
    logic [1:0]  next_mode, crtc_fn, pio_port;
    logic [11:0] wr_bank;
    logic [3:0]  rd_rom;
    logic        crtc_cs, pio_cs, cpu_wait;
    logic [7:0]  io_rdata;

    gabank_ctrl dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // model state
    logic [1:0] m_mode; logic m_lo, m_hi, m_disk, m_pen, m_col, m_irq;
    logic [2:0] m_cfg; logic [4:0] m_val;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_banks(input logic [2:0] c);
        case (c)
            3'd0: return {3'd3, 3'd2, 3'd1, 3'd0};
            3'd1: return {3'd7, 3'd2, 3'd1, 3'd0};
            3'd2: return {3'd7, 3'd6, 3'd5, 3'd4};
            3'd3: return {3'd7, 3'd2, 3'd3, 3'd0};
            default: return {3'd3, 3'd2, c, 3'd0};
        endcase
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a, input logic rd,
                                             input logic [7:0] cr, input logic [7:0] pr);
        logic [7:0] v = 8'hFF;
        if (rd && !a[11]) v &= pr;
        if (rd && !a[14] && a[9]) v &= cr;
        return v;
    endfunction

    task automatic check_regs();
        chk(next_mode == m_mode, "R4 mode", next_mode, m_mode);
        chk({low_rom_en, high_rom_en} == {m_lo, m_hi}, "R4 rom", {low_rom_en, high_rom_en}, {m_lo, m_hi});
        chk(irq_cnt_clr == m_irq, "R4 irq", irq_cnt_clr, m_irq);
        chk({pen_stb, colour_stb} == {m_pen, m_col}, "R3 strobes", {pen_stb, colour_stb}, {m_pen, m_col});
        if (m_pen || m_col) chk(ga_val == m_val, "R3 value", ga_val, m_val);
        chk(wr_bank == exp_banks(m_cfg), "R5 banks", wr_bank, exp_banks(m_cfg));
        chk(rd_rom == {m_hi, 2'b00, m_lo}, "R6 rd_rom", rd_rom, {m_hi, 2'b00, m_lo});
        chk(upper_disk == m_disk, "R10 upper", upper_disk, m_disk);
        chk(cpu_wait == ((cyc % 4) != 0), "R11 wait", cpu_wait, (cyc % 4) != 0);
    endtask

    // One bus step: check registered outputs, drive, check decode, update model.
    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic wr, input logic rd,
                        input logic x, input logic [7:0] cr, input logic [7:0] pr);
        logic [7:0] rdv, v;
        logic io;
        check_regs();
        io_addr = a; io_wdata = d; io_wr = wr; io_rd = rd; exp128_en = x;
        crtc_rdata = cr; pio_rdata = pr;
        #1;
        io = wr | rd;
        rdv = exp_rdata(a, rd, cr, pr);
        chk(crtc_cs == (io && !a[14]) && crtc_fn == a[9:8], "R7 crtc", {crtc_cs, crtc_fn}, {io && !a[14], a[9:8]});
        chk(pio_cs == (io && !a[11]) && pio_port == a[9:8], "R7 pio", {pio_cs, pio_port}, {io && !a[11], a[9:8]});
        chk(io_rdata == rdv, "R8 rdata", io_rdata, rdv);
        m_pen = 0; m_col = 0; m_irq = 0;
        v = rd ? rdv : d;
        if (io && a[15:14] == 2'b01) begin
            case (v[7:6])
                2'b00: begin m_pen = 1; m_val = v[4:0]; end
                2'b01: begin m_col = 1; m_val = v[4:0]; end
                2'b10: begin m_mode = v[1:0]; m_lo = !v[2]; m_hi = !v[3]; m_irq = v[4]; end
                default: if (x) m_cfg = v[2:0];
            endcase
        end
        if (wr && !a[13]) m_disk = (d == 8'd7);
        @(posedge clk); #1;
        io_wr = 0; io_rd = 0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        m_mode = 2; m_lo = 1; m_hi = 1; m_disk = 0; m_pen = 0; m_col = 0; m_irq = 0; m_cfg = 0; m_val = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(next_mode == 2 && rd_rom == 4'b1001 && wr_bank == 12'b011_010_001_000 && !upper_disk,
            "R1 reset", {next_mode, rd_rom, wr_bank}, {2'd2, 4'b1001, 12'b011_010_001_000});
        chk(!(pen_stb || colour_stb || irq_cnt_clr), "R1 strobes", {pen_stb, colour_stb, irq_cnt_clr}, 0);
        // R2: pen byte outside range is ignored
        step(16'hBF00, 8'h05, 1, 0, 0, 8'hFF, 8'hFF);
        chk(!pen_stb, "R2 out of range", pen_stb, 0);
        // R3/R4 directed
        step(16'h7F00, 8'h13, 1, 0, 0, 8'hFF, 8'hFF);
        step(16'h7F00, 8'h5A, 1, 0, 0, 8'hFF, 8'hFF);
        step(16'h7F00, 8'h9C, 1, 0, 0, 8'hFF, 8'hFF);
        chk(irq_cnt_clr && rd_rom == 4'b0000 && next_mode == 0, "R4 directed", {irq_cnt_clr, rd_rom}, 5'b10000);
        // R5: locked, then enabled
        step(16'h7F00, 8'hC2, 1, 0, 0, 8'hFF, 8'hFF);
        chk(wr_bank == exp_banks(3'd0), "R5 locked", wr_bank, exp_banks(3'd0));
        step(16'h7F00, 8'hC2, 1, 0, 1, 8'hFF, 8'hFF);
        chk(wr_bank == exp_banks(3'd2), "R5 enabled", wr_bank, exp_banks(3'd2));
        // R9: read at 0x4000 selects PIO and gate array; colour byte comes from the merged bus
        step(16'h4000, 8'h00, 0, 1, 1, 8'h00, 8'h47);
        chk(colour_stb && ga_val == 5'h07, "R9 read sample", {colour_stb, ga_val}, {1'b1, 5'h07});
        // R10: disk ROM select and deselect
        step(16'hDF00, 8'h07, 1, 0, 1, 8'hFF, 8'hFF);
        chk(upper_disk, "R10 select", upper_disk, 1);
        step(16'hDF00, 8'h06, 1, 0, 1, 8'hFF, 8'hFF);
        chk(!upper_disk, "R10 deselect", upper_disk, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a; logic [7:0] d; int op;
            a = $urandom;
            if ($urandom_range(0, 2) != 0) a[15:14] = 2'b01;
            d = $urandom;
            op = $urandom_range(0, 2);
            step(a, d, op == 1, op == 2, ($urandom_range(0, 3) != 0), 8'($urandom), 8'($urandom));
        end
        check_regs();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule